// File: doc/BRIEF.md
# Oversampled SPI Target with Select-Driven Reset

This block is the target (slave) side of an SPI link. All bit timing comes from the serial clock that the external controller drives. The block works in the system clock domain: the serial clock, the data-in line and the active-low select each pass through a synchronizer chain, and the block detects serial clock edges by comparing successive samples. For this to work, the serial clock must run no faster than one quarter of the system clock. Each byte the controller clocks in is exchanged for the byte waiting in a one-word transmit buffer. The received byte lands in a one-word receive buffer.

Clock polarity and phase are set by two configuration pins, which together select SPI modes 0 to 3. A third pin selects LSB-first order in place of the default MSB-first order. An incoming bit is captured into a one-bit holding register on the sampling edge. On the opposite edge it moves into the receive shifter, so input capture and output shifting use opposite edges. While the select is high, the block ignores the serial clock and data-in, clears all shift and count state, and drives the data-out line to 1 so that several targets can share the line as a wired-AND. When the clock phase is 0, the falling edge of the select loads the first transmit bit onto the data-out line before any clock edge arrives.

Software-side traffic uses two streams. The transmit stream has `tx_valid`/`tx_ready`. `tx_ready` is high exactly when the buffer is empty, and a word is taken on a cycle where both are high. The receive stream has `rx_valid`/`rx_ready`. `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high. The serial link cannot be stalled, so a byte that completes while the previous one is still unread replaces it. A transmit word is committed to the shifter when a byte's first bit is loaded. With clock phase 0, that load happens on the final edge of the previous byte. A plain status port reports completion, underrun and buffer state, and `stat_rd` clears the two sticky flags.

Top module: `spi_slave`

## Requirements
- R1: With `cfg_cpol` giving the idle level of `sclk` and `cfg_cpha` = 0 (sample on the edge leaving idle) or 1 (sample on the edge returning to idle), the block exchanges full bytes correctly in all four modes.
- R2: With `cfg_lsb_first` = 0, bit 7 is shifted first in both directions; with `cfg_lsb_first` = 1, bit 0 is shifted first.
- R3: While `ss_n` is high, `miso` is 1.
- R4: Raising `ss_n` in the middle of a byte discards the partial byte: `rx_valid` and `stat_done` stay low, and the next selection starts a fresh byte.
- R5: With `cfg_cpha` = 0, the first bit of the loaded transmit word appears on `miso` after `ss_n` falls and before the first `sclk` edge.
- R6: `tx_ready` is 1 while the transmit buffer is empty. An accepted word is the next byte sent, and the buffer becomes empty again when that word is loaded into the shifter.
- R7: After a byte completes, `rx_valid` is 1 and `rx_data` holds the byte until `rx_ready` is high. A later byte overwrites an unread one.
- R8: If the transmit buffer is empty when a byte is loaded, the block resends the last transmitted word, and `stat_underrun` is set when that byte's first bit is sampled.
- R9: `stat_done` is set when a byte completes. A one-cycle pulse on `stat_rd` clears `stat_done` and `stat_underrun`.
- R10: With `cfg_irq_on_done` = 0, `irq` is 1 while the transmit buffer is empty. With `cfg_irq_on_done` = 1, `irq` follows `stat_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data from the controller |
| ss_n | input | 1 | Active-low target select |
| miso | output | 1 | Serial data to the controller, 1 when deselected |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: sample on the edge leaving idle; 1: sample on the edge returning to idle |
| cfg_lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| cfg_irq_on_done | input | 1 | Interrupt source: 0 transmit buffer empty, 1 byte complete |
| tx_data | input | 8 | Transmit stream data |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | 8 | Receive stream data |
| rx_valid | output | 1 | Receive stream valid |
| rx_ready | input | 1 | Receive stream consumer ready |
| stat_rd | input | 1 | Status read strobe, clears the sticky flags |
| stat_done | output | 1 | Sticky byte-complete flag |
| stat_underrun | output | 1 | Sticky underrun flag |
| stat_tx_empty | output | 1 | Transmit buffer empty |
| irq | output | 1 | Selected interrupt |

## Verification
The assertions check on every cycle the properties that hold locally. While the select is high, the data-out line is at 1. An unread received byte stays stable. Both sticky flags hold until a read clears them. An accepted transmit word closes the transmit handshake on the next cycle. The bench scenarios cover what only a full exchange can show: correct bytes in each mode and bit order, the first bit appearing before any clock edge in phase 0, a word queued between bytes being sent, the last word being resent on underrun, a partial byte being dropped when the select rises early, and the two interrupt sources.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_mode_t;
endpackage

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= RESET_VAL;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= RESET_VAL;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slave_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         mosi_s,
  input  logic         ss_n_s,
  input  spi_mode_t    mode,
  input  logic         buf_full,
  input  logic [W-1:0] buf_data,
  output logic         buf_take,
  output logic         miso,
  output logic         byte_done,
  output logic [W-1:0] byte_data,
  output logic         underrun_evt
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             sclk_d, ss_d;
  logic [CNT_W-1:0] bit_cnt;
  logic             rxd;
  logic [W-1:0]     rx_sr, tx_sr, last_tx;
  logic             stale;

  logic active, rise, fall, lead, trail, sample_e, drive_e, sel_edge;
  logic load, shift;
  logic [W-1:0] load_val;

  assign active   = !ss_n_s;
  assign rise     = sclk_s && !sclk_d;
  assign fall     = !sclk_s && sclk_d;
  assign lead     = active && (mode.cpol ? fall : rise);
  assign trail    = active && (mode.cpol ? rise : fall);
  assign sample_e = mode.cpha ? trail : lead;
  assign drive_e  = mode.cpha ? lead : trail;
  assign sel_edge = ss_d && !ss_n_s;

  assign load     = (drive_e && bit_cnt == '0) || (sel_edge && !mode.cpha);
  assign shift    = drive_e && bit_cnt != '0;
  assign load_val = buf_full ? buf_data : last_tx;
  assign buf_take = load && buf_full;

  assign byte_done    = sample_e && bit_cnt == LAST;
  assign byte_data    = mode.lsb_first ? {mosi_s, rx_sr[W-1:1]} : {rx_sr[W-2:0], mosi_s};
  assign underrun_evt = sample_e && bit_cnt == '0 && stale;
  assign miso         = active ? (mode.lsb_first ? tx_sr[0] : tx_sr[W-1]) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      ss_d   <= ss_n_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rxd     <= 1'b0;
      rx_sr   <= '0;
      tx_sr   <= '1;
      last_tx <= '0;
      stale   <= 1'b0;
    end else if (!active) begin
      bit_cnt <= '0;
      rxd     <= 1'b0;
      rx_sr   <= '0;
      tx_sr   <= '1;
      stale   <= 1'b0;
    end else begin
      if (sample_e) begin
        rxd     <= mosi_s;
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end
      if (drive_e)
        rx_sr <= mode.lsb_first ? {rxd, rx_sr[W-1:1]} : {rx_sr[W-2:0], rxd};
      if (load) begin
        tx_sr   <= load_val;
        last_tx <= load_val;
        stale   <= !buf_full;
      end else if (shift) begin
        tx_sr <= mode.lsb_first ? {1'b1, tx_sr[W-1:1]} : {tx_sr[W-2:0], 1'b1};
      end
    end
  end

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_s |=> !byte_done && !underrun_evt) else $error("deselect must clear state"); // R4
endmodule

// File: rtl/spi_slave_bufs.sv
module spi_slave_bufs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic         buf_full,
  output logic [W-1:0] buf_data,
  input  logic         buf_take,
  input  logic         byte_done,
  input  logic [W-1:0] byte_data,
  input  logic         underrun_evt,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  input  logic         stat_rd,
  input  logic         irq_on_done,
  output logic         stat_done,
  output logic         stat_underrun,
  output logic         irq
);
  assign tx_ready = !buf_full;
  assign irq      = irq_on_done ? stat_done : !buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (tx_valid && !buf_full) begin
      buf_full <= 1'b1;
      buf_data <= tx_data;
    end else if (buf_take) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_done) begin
      rx_valid <= 1'b1;
      rx_data  <= byte_data;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_done     <= 1'b0;
      stat_underrun <= 1'b0;
    end else begin
      if (byte_done)    stat_done <= 1'b1;
      else if (stat_rd) stat_done <= 1'b0;
      if (underrun_evt) stat_underrun <= 1'b1;
      else if (stat_rd) stat_underrun <= 1'b0;
    end
  end

  AST_TX_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready) else $error("accepted word must fill buffer"); // R6
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !byte_done |=> rx_valid && $stable(rx_data)) else $error("rx word lost"); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_underrun && !stat_rd |=> stat_underrun) else $error("underrun flag dropped"); // R8
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !byte_done |=> !stat_done) else $error("read must clear done"); // R9
endmodule

// File: rtl/spi_slave.sv
module spi_slave
  import spi_slave_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         mosi,
  input  logic         ss_n,
  output logic         miso,
  input  logic         cfg_cpol,
  input  logic         cfg_cpha,
  input  logic         cfg_lsb_first,
  input  logic         cfg_irq_on_done,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  input  logic         stat_rd,
  output logic         stat_done,
  output logic         stat_underrun,
  output logic         stat_tx_empty,
  output logic         irq
);
  logic [2:0]   pins_s;
  logic         buf_full, buf_take, byte_done, underrun_evt;
  logic [W-1:0] buf_data, byte_data;
  spi_mode_t    mode;

  assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};
  assign stat_tx_empty = !buf_full;

  spi_slave_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n, sclk, mosi}), .q(pins_s)
  );

  spi_slave_engine #(.W(W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[1]), .mosi_s(pins_s[0]), .ss_n_s(pins_s[2]),
    .mode(mode), .buf_full(buf_full), .buf_data(buf_data), .buf_take(buf_take),
    .miso(miso), .byte_done(byte_done), .byte_data(byte_data),
    .underrun_evt(underrun_evt)
  );

  spi_slave_bufs #(.W(W)) u_bufs (
    .clk(clk), .rst_n(rst_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .buf_full(buf_full), .buf_data(buf_data), .buf_take(buf_take),
    .byte_done(byte_done), .byte_data(byte_data), .underrun_evt(underrun_evt),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .stat_rd(stat_rd), .irq_on_done(cfg_irq_on_done),
    .stat_done(stat_done), .stat_underrun(stat_underrun), .irq(irq)
  );

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s[2] |-> miso) else $error("miso not idle while deselected"); // R3
endmodule

// File: tb/test_spi_slave.sv
module test_spi_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic cpol = 1'b0, cpha = 1'b0, lsb = 1'b0, irq_sel = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, stat_rd = 1'b0;
  logic miso, tx_ready, rx_valid, stat_done, stat_underrun, stat_tx_empty, irq;
  logic [7:0] rx_data;
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_slave i_spi_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb), .cfg_irq_on_done(irq_sel),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .stat_rd(stat_rd), .stat_done(stat_done), .stat_underrun(stat_underrun),
    .stat_tx_empty(stat_tx_empty), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic a, input logic l);
    cpol = p; cpha = a; lsb = l; sclk = p;
    wait_n(H);
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      int b;
      b = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi = mo[b];
        wait_n(H);
        mi[b] = miso;
        sclk = ~sclk;
        wait_n(H);
        sclk = ~sclk;
      end else begin
        sclk = ~sclk;
        mosi = mo[b];
        wait_n(H);
        mi[b] = miso;
        sclk = ~sclk;
        wait_n(H);
      end
    end
    wait_n(H);
  endtask

  task automatic t_reset();
    check("R3 reset miso", miso, 1);
    check("R6 reset tx_ready", tx_ready, 1);
    check("R7 reset rx_valid", rx_valid, 0);
    check("R9 reset done", stat_done, 0);
    check("R10 reset irq tx-empty", irq, 1);
  endtask

  task automatic t_mode(input logic p, input logic a, input logic l,
                        input logic [7:0] txb, input logic [7:0] rxb);
    logic [7:0] mi;
    set_mode(p, a, l);
    push_tx(txb);
    check("R6 tx_ready low after push", tx_ready, 0);
    ss_n = 1'b0;
    wait_n(H);
    if (!a) check("R5 first bit before clock", miso, l ? txb[0] : txb[7]);
    xfer(rxb, 8, mi);
    ss_n = 1'b1;
    wait_n(H);
    check(l ? "R2 miso byte lsb-first" : "R1 miso byte", mi, txb);
    check("R1 rx_valid", rx_valid, 1);
    check(l ? "R2 rx byte lsb-first" : "R1 rx byte", rx_data, rxb);
    check("R3 miso idle after deselect", miso, 1);
    check("R9 done set", stat_done, 1);
    check("R8 no underrun", stat_underrun, 0);
    check("R6 buffer emptied", tx_ready, 1);
    read_status();
    check("R9 done cleared", stat_done, 0);
    pop_rx();
    check("R7 rx popped", rx_valid, 0);
  endtask

  task automatic t_queue_between_bytes();
    logic [7:0] m1, m2;
    set_mode(1'b0, 1'b1, 1'b0);
    push_tx(8'h3C);
    ss_n = 1'b0;
    wait_n(H);
    xfer(8'h11, 8, m1);
    push_tx(8'hC3);
    check("R7 rx held unread", rx_data, 8'h11);
    xfer(8'h22, 8, m2);
    ss_n = 1'b1;
    wait_n(H);
    check("R6 first word", m1, 8'h3C);
    check("R6 queued word", m2, 8'hC3);
    check("R7 overwrite unread", rx_data, 8'h22);
    check("R8 no underrun when queued", stat_underrun, 0);
    read_status();
    pop_rx();
  endtask

  task automatic t_underrun();
    logic [7:0] m1, m2;
    set_mode(1'b0, 1'b0, 1'b0);
    push_tx(8'hA7);
    ss_n = 1'b0;
    wait_n(H);
    xfer(8'h01, 8, m1);
    check("R8 no underrun before second byte", stat_underrun, 0);
    xfer(8'h02, 8, m2);
    ss_n = 1'b1;
    wait_n(H);
    check("R8 resend last word", m2, 8'hA7);
    check("R8 underrun flagged", stat_underrun, 1);
    read_status();
    check("R9 underrun cleared", stat_underrun, 0);
    pop_rx();
  endtask

  task automatic t_abort();
    logic [7:0] mi;
    set_mode(1'b0, 1'b0, 1'b0);
    push_tx(8'h5A);
    ss_n = 1'b0;
    wait_n(H);
    xfer(8'hFF, 4, mi);
    ss_n = 1'b1;
    wait_n(H);
    check("R3 miso idle after abort", miso, 1);
    check("R4 no rx on partial", rx_valid, 0);
    check("R4 no done on partial", stat_done, 0);
    push_tx(8'h96);
    ss_n = 1'b0;
    wait_n(H);
    xfer(8'h4B, 8, mi);
    ss_n = 1'b1;
    wait_n(H);
    check("R4 fresh byte after abort rx", rx_data, 8'h4B);
    check("R4 fresh byte after abort tx", mi, 8'h96);
    read_status();
    pop_rx();
  endtask

  task automatic t_irq();
    logic [7:0] mi;
    set_mode(1'b1, 1'b1, 1'b0);
    irq_sel = 1'b1;
    wait_n(2);
    check("R10 irq done source idle", irq, 0);
    push_tx(8'h0F);
    ss_n = 1'b0;
    wait_n(H);
    xfer(8'hF0, 8, mi);
    ss_n = 1'b1;
    wait_n(H);
    check("R10 irq on done", irq, 1);
    read_status();
    check("R10 irq cleared by read", irq, 0);
    pop_rx();
    irq_sel = 1'b0;
    push_tx(8'h77);
    check("R10 irq low with full buffer", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_mode(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3E);
    t_mode(1'b0, 1'b1, 1'b0, 8'h81, 8'h7E);
    t_mode(1'b1, 1'b0, 1'b0, 8'hC6, 8'h19);
    t_mode(1'b1, 1'b1, 1'b0, 8'h2D, 8'hE4);
    t_mode(1'b0, 1'b0, 1'b1, 8'hB1, 8'h4C);
    t_mode(1'b1, 1'b1, 1'b1, 8'h6E, 8'h93);
    t_queue_between_bytes();
    t_underrun();
    t_abort();
    t_irq();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule